// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block steers the direction input of an external RS-485 line transceiver when the UART works in 9-bit multidrop mode. The transceiver goes to transmit as soon as the transmitter reports data to send. Once the transmitter is idle and its shift register is empty, the block waits a programmable number of bit times and then returns the transceiver to receive. The bit times are counted on a one-cycle tick from the baud generator.

The level it drives can be inverted, and it can drive either the RTS or the DTR modem pin. The pin it does not drive, and both pins whenever direction control is off, carry the values that software wrote to the modem-control bits. A new transmission that starts during the wait cancels the countdown, and the transceiver stays in transmit.

Top module: `rs485_dir_ctl`

## Requirements
- R1: After reset the controller is in the receive state. While `multidrop_en` or `dir_ctl_en` is 0, `rts_pin` equals `sw_rts` and `dtr_pin` equals `sw_dtr` in every cycle.
- R2: With control active, `tx_busy` = 1 puts the driven pin at the transmit level in the cycle after the clock edge that samples it. The pin holds that level while `tx_busy` is 1 or `tsr_empty` is 0.
- R3: The countdown loads `turn_delay` = D in the clock edge that first samples `tx_busy` = 0 with `tsr_empty` = 1. A `bit_tick` in that same cycle is not counted. The pin returns to the receive level after the edge that samples the (D+1)-th later `bit_tick`.
- R4: With D = 0, the line turns around on the first `bit_tick` after the cycle that loads the countdown.
- R5: With `pol_invert` = 0, the driven pin is 0 while transmitting and 1 while receiving.
- R6: With `pol_invert` = 1, the driven pin is 1 while transmitting and 0 while receiving.
- R7: `use_dtr` = 0 drives `rts_pin`, and `use_dtr` = 1 drives `dtr_pin`. The pin that is not driven always equals its software value.
- R8: `tx_busy` = 1 during the countdown cancels it. The pin stays at the transmit level, and the next countdown reloads the full delay.
- R9: Turning multidrop mode off returns the controller to the receive state. When it is turned back on while idle, the driven pin shows the receive level.
- R10: `turn_delay` is sampled only when the countdown loads. A change to it during the countdown has no effect on that countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_busy | input | 1 | Transmitter has data to send |
| tsr_empty | input | 1 | Transmit shift register has shifted its last bit |
| turn_delay | input | 8 | Turn-around delay in bit times |
| multidrop_en | input | 1 | 9-bit multidrop mode enable |
| dir_ctl_en | input | 1 | Transmitter controls the chosen pin |
| use_dtr | input | 1 | 0 drives RTS, 1 drives DTR |
| pol_invert | input | 1 | Swap the transmit and receive levels |
| sw_rts | input | 1 | Software RTS value |
| sw_dtr | input | 1 | Software DTR value |
| rts_pin | output | 1 | RTS pin level |
| dtr_pin | output | 1 | DTR pin level |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse and that `tx_busy` and `tsr_empty` are synchronous to `clk`. They also assume that the shift register reports empty only after the transmitter drops busy. The stimulus changes every input at the falling clock edge. It raises `bit_tick` for single cycles only, spaced by idle cycles or given on consecutive cycles, and it never claims an empty shift register while `tx_busy` is high, except in the cancel case, where `tsr_empty` is low.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_RX   = 2'd0,
    DIR_TX   = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_turn_timer.sv
module rs485_turn_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);

  AST_DEC_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !cnt_zero); // R3
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       tx_busy,
  input  logic       tsr_empty,
  input  logic       bit_tick,
  input  logic       cnt_zero,
  output logic       cnt_load,
  output logic       cnt_dec,
  output logic       line_tx
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (!active) begin
      state_d = DIR_RX;
    end else begin
      unique case (state_q)
        DIR_RX: begin
          if (tx_busy) state_d = DIR_TX;
        end
        DIR_TX: begin
          if (!tx_busy && tsr_empty) begin
            state_d  = DIR_HOLD;
            cnt_load = 1'b1;
          end
        end
        DIR_HOLD: begin
          if (tx_busy) begin
            state_d = DIR_TX;
          end else if (bit_tick) begin
            if (cnt_zero) state_d = DIR_RX;
            else          cnt_dec = 1'b1;
          end
        end
        default: state_d = DIR_RX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DIR_RX;
    else        state_q <= state_d;
  end

  assign line_tx = (state_q != DIR_RX);

  AST_INACTIVE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state_q == DIR_RX)); // R9
  AST_BUSY_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tx_busy) |=> (state_q == DIR_TX)); // R8
  AST_TURN_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (active && state_q == DIR_HOLD && !tx_busy && bit_tick && cnt_zero)
      |=> (state_q == DIR_RX)); // R3
  AST_STAY_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (active && state_q == DIR_TX && !tsr_empty) |=> (state_q == DIR_TX)); // R2
endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux (
  input  logic line_tx,
  input  logic ctl_on,
  input  logic use_dtr,
  input  logic pol_invert,
  input  logic sw_rts,
  input  logic sw_dtr,
  output logic rts_pin,
  output logic dtr_pin
);
  logic dir_level;

  assign dir_level = ~line_tx ^ pol_invert;

  always_comb begin
    rts_pin = sw_rts;
    dtr_pin = sw_dtr;
    if (ctl_on) begin
      if (use_dtr) dtr_pin = dir_level;
      else         rts_pin = dir_level;
    end
  end
endmodule

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl #(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               tx_busy,
  input  logic               tsr_empty,
  input  logic [DELAY_W-1:0] turn_delay,
  input  logic               multidrop_en,
  input  logic               dir_ctl_en,
  input  logic               use_dtr,
  input  logic               pol_invert,
  input  logic               sw_rts,
  input  logic               sw_dtr,
  output logic               rts_pin,
  output logic               dtr_pin
);
  logic ctl_on;
  logic cnt_load, cnt_dec, cnt_zero, line_tx;
  logic driven_pin, idle_pin;

  assign ctl_on = multidrop_en & dir_ctl_en;

  rs485_dir_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (ctl_on),
    .tx_busy   (tx_busy),
    .tsr_empty (tsr_empty),
    .bit_tick  (bit_tick),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec),
    .line_tx   (line_tx)
  );

  rs485_turn_timer #(.CNT_W(DELAY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (turn_delay),
    .dec      (cnt_dec),
    .cnt_zero (cnt_zero)
  );

  rs485_pin_mux u_mux (
    .line_tx    (line_tx),
    .ctl_on     (ctl_on),
    .use_dtr    (use_dtr),
    .pol_invert (pol_invert),
    .sw_rts     (sw_rts),
    .sw_dtr     (sw_dtr),
    .rts_pin    (rts_pin),
    .dtr_pin    (dtr_pin)
  );

  assign driven_pin = use_dtr ? dtr_pin : rts_pin;
  assign idle_pin   = use_dtr ? rts_pin : dtr_pin;

  AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_on && tx_busy) ##1 ctl_on |-> (driven_pin == pol_invert)); // R2
  AST_OTHER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_on |-> (idle_pin == (use_dtr ? sw_rts : sw_dtr))); // R7
  AST_OFF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_on |-> (rts_pin == sw_rts && dtr_pin == sw_dtr)); // R1
endmodule

// File: tb/rs485_dir_ctl_tb.sv
module rs485_dir_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, tx_busy = 1'b0, tsr_empty = 1'b1;
  logic [7:0] turn_delay = 8'd0;
  logic       multidrop_en = 1'b1, dir_ctl_en = 1'b1, use_dtr = 1'b0, pol_invert = 1'b0;
  logic       sw_rts = 1'b0, sw_dtr = 1'b0;
  logic       rts_pin, dtr_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  er;
    logic  ed;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  rs485_dir_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_busy(tx_busy),
    .tsr_empty(tsr_empty), .turn_delay(turn_delay), .multidrop_en(multidrop_en),
    .dir_ctl_en(dir_ctl_en), .use_dtr(use_dtr), .pol_invert(pol_invert),
    .sw_rts(sw_rts), .sw_dtr(sw_dtr), .rts_pin(rts_pin), .dtr_pin(dtr_pin)
  );

  // monitor: compares each expectation after the edge that produced it
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (rts_pin !== e.er || dtr_pin !== e.ed) begin
        n_bad++;
        $display("FAIL %s: rts/dtr actual %b%b expected %b%b", e.tag, rts_pin, dtr_pin, e.er, e.ed);
      end
    end
  end

  task automatic cyc(input logic busy, input logic empty, input logic tick,
                     input logic er, input logic ed, input string tag);
    exp_t e;
    @(negedge clk);
    tx_busy = busy; tsr_empty = empty; bit_tick = tick;
    e.er = er; e.ed = ed; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #3;
  endtask

  task automatic direct(input logic er, input logic ed, input string tag);
    n_chk++;
    if (rts_pin !== er || dtr_pin !== ed) begin
      n_bad++;
      $display("FAIL %s: rts/dtr actual %b%b expected %b%b", tag, rts_pin, dtr_pin, er, ed);
    end
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual hung expected done");
          $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
          $finish;
        end
      end
    join_none

    repeat (3) @(posedge clk);
    #1 direct(1'b1, 1'b0, "R1 reset receive level");
    @(negedge clk) rst_n = 1'b1;

    // R3 delay 2
    turn_delay = 8'd2;
    cyc(0,1,0, 1,0, "R5 idle receive high");
    cyc(1,0,0, 0,0, "R2 busy to transmit");
    cyc(0,0,1, 0,0, "R2 shifter not empty");
    cyc(0,1,1, 0,0, "R3 load, tick ignored");
    cyc(0,1,1, 0,0, "R3 tick 1");
    cyc(0,1,0, 0,0, "R3 gap");
    cyc(0,1,1, 0,0, "R3 tick 2");
    cyc(0,1,0, 0,0, "R3 gap");
    cyc(0,1,1, 1,0, "R3 tick 3 turns");

    // R4 delay 0
    turn_delay = 8'd0;
    cyc(1,0,0, 0,0, "R4 busy");
    cyc(0,1,1, 0,0, "R4 load");
    cyc(0,1,1, 1,0, "R4 first tick turns");

    // R8 cancel with delay 1
    turn_delay = 8'd1;
    cyc(1,0,0, 0,0, "R8 busy");
    cyc(0,1,0, 0,0, "R8 load");
    cyc(0,1,1, 0,0, "R8 tick 1");
    cyc(1,0,1, 0,0, "R8 cancel");
    cyc(0,1,0, 0,0, "R8 reload");
    cyc(0,1,1, 0,0, "R8 tick after reload");
    cyc(0,1,1, 1,0, "R8 full delay then turn");

    // R10 delay change mid countdown
    turn_delay = 8'd3;
    cyc(1,0,0, 0,0, "R10 busy");
    cyc(0,1,0, 0,0, "R10 load 3");
    turn_delay = 8'd0;
    cyc(0,1,1, 0,0, "R10 tick 1");
    cyc(0,1,1, 0,0, "R10 tick 2");
    cyc(0,1,1, 0,0, "R10 tick 3");
    cyc(0,1,1, 1,0, "R10 tick 4 turns");

    // R6 inversion
    pol_invert = 1'b1;
    cyc(0,1,0, 0,0, "R6 receive low");
    cyc(1,0,0, 1,0, "R6 transmit high");
    cyc(0,1,0, 1,0, "R6 load");
    cyc(0,1,1, 0,0, "R6 turn low");
    pol_invert = 1'b0;

    // R7 DTR selected
    use_dtr = 1'b1; sw_rts = 1'b1;
    cyc(0,1,0, 1,1, "R7 dtr receive, rts sw");
    cyc(1,0,0, 1,0, "R7 dtr transmit");
    sw_rts = 1'b0;
    cyc(1,0,0, 0,0, "R7 rts follows sw");
    cyc(0,1,0, 0,0, "R7 load");
    cyc(0,1,1, 0,1, "R7 dtr turn");
    use_dtr = 1'b0;

    // R1 control disabled
    dir_ctl_en = 1'b0; sw_rts = 1'b1; sw_dtr = 1'b0;
    cyc(1,0,0, 1,0, "R1 disabled follows sw");
    sw_rts = 1'b0; sw_dtr = 1'b1;
    cyc(1,0,0, 0,1, "R1 disabled sw change");
    dir_ctl_en = 1'b1;
    cyc(0,1,0, 1,1, "R1 re-enabled receive");

    // R9 multidrop off during transmit
    sw_rts = 1'b1; sw_dtr = 1'b1;
    cyc(1,0,0, 0,1, "R9 transmit");
    multidrop_en = 1'b0;
    cyc(1,0,0, 1,1, "R9 off follows sw");
    multidrop_en = 1'b1; sw_rts = 1'b0;
    cyc(0,1,0, 1,1, "R9 back on receive");

    wait (sb.size() == 0);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule